// File: doc/BRIEF.md
# Power-up configuration select controller

This controller decides which stored register configuration a programmable device loads. It acts once at power-on and again at run time. When the power-on reset is released, it samples a mode strap and keeps that value until the next power-on. A high strap sets hardware-select mode: the two shared pins become select inputs, and their value names one of four stored configurations. A low strap, or a floating strap pulled low, sets serial-bus mode: the shared pins belong to a serial bus, and bus access is enabled.

After power-on the block issues exactly one load strobe, a one-cycle pulse that carries a configuration index and a defaults flag. Further loads come from one of two sources, never both. In hardware-select mode a single select pin can change once the holdoff has passed. In serial-bus mode the host asks for a load. Each load is followed by a busy window. A pin change made during that window is ignored. A host request made during that window is held and served as soon as the window closes.

Top module: `cfg_sel_ctrl`

## Requirements
- R1: The strap sampled at reset release fixes the mode until the next power-on. Strap 1 selects hardware-select mode, where bus_en is 0. Strap 0 selects serial-bus mode, where bus_en is 1. A later change on strap_in has no effect.
- R2: Exactly one load_stb follows each reset release. In hardware-select mode it carries load_idx = {sel1_in, sel0_in} and load_dflt = 0.
- R3: In serial-bus mode the initial load has load_idx = 0. Its load_dflt equals reg0_b7: 1 means the bus default settings, 0 means configuration 0.
- R4: In serial-bus mode, select pin activity produces no strobe. A host_req pulse while idle produces one strobe on the next clock edge, with load_idx = host_idx and load_dflt = 0. In hardware-select mode host_req has no effect.
- R5: Run-time pin changes are honoured only in hardware-select mode with reg0_b7 = 0. They are also honoured only after CLK_HZ/100 cycles (10 ms) since reset release. Changes made earlier are ignored.
- R6: An honoured change of exactly one select pin produces one strobe, with load_idx equal to the new {sel1_in, sel0_in}. That strobe clears err.
- R7: If both select pins change in the same sampled interval, err goes to 1 and stays at 1 until the next strobe, and no strobe is issued.
- R8: busy is high from the strobe cycle for exactly CLK_HZ/1000 cycles (1 ms). Pin changes during that time are ignored.
- R9: A host_req that arrives while busy is held pending, and a later request replaces the pending index. It is served on the first clock edge at which busy is low, so the strobe appears one cycle after busy falls.
- R10: load_stb is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| strap_in | input | 1 | Mode strap (1 = hardware select, 0 = serial bus) |
| sel1_in | input | 1 | Shared pin, select bit 1 in hardware-select mode |
| sel0_in | input | 1 | Shared pin, select bit 0 in hardware-select mode |
| reg0_b7 | input | 1 | Register control bit: defaults on bus load / run-time pin lock |
| host_req | input | 1 | Host load request, one-cycle pulse |
| host_idx | input | 2 | Configuration index for a host request |
| load_stb | output | 1 | One-cycle load strobe |
| load_idx | output | 2 | Configuration index, valid with load_stb |
| load_dflt | output | 1 | Load bus default settings, valid with load_stb |
| bus_en | output | 1 | Serial-bus access enabled |
| busy | output | 1 | Load window in progress |
| err | output | 1 | Illegal double pin change seen |

## Verification
Each internal fault shows at the ports within a few cycles.

- **Wrongly latched mode:** bus_en is wrong from the first strobe, the initial index is wrong, or both.
- **Wrong previous-pin register:** a strobe appears where none should, or the expected strobe is missing, two synchronizer delays after the pin edge.
- **Wrong holdoff or window counter:** the edge of the busy pulse moves, or a change on either side of the holdoff is handled wrongly, so the error shows as a cycle count.
- **Lost pending request:** the strobe that should follow the busy fall by one cycle does not appear.

// File: rtl/cfg_sel_ctrl.sv
module cfg_sel_ctrl #(
  parameter int CLK_HZ = 100_000_000
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       strap_in,
  input  logic       sel1_in,
  input  logic       sel0_in,
  input  logic       reg0_b7,
  input  logic       host_req,
  input  logic [1:0] host_idx,
  output logic       load_stb,
  output logic [1:0] load_idx,
  output logic       load_dflt,
  output logic       bus_en,
  output logic       busy,
  output logic       err
);
  localparam int HOLD_CYC = CLK_HZ / 100;
  localparam int WIN_CYC  = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam int WW = $clog2(WIN_CYC + 1);

  logic [2:0]    sy1, sy2;
  logic [1:0]    pcnt, prev, pend_idx;
  logic          init_done, mode_hw, pend;
  logic [HW-1:0] hcnt;
  logic [WW-1:0] wcnt;

  wire [1:0] pins    = sy2[1:0];
  wire [1:0] diff    = pins ^ prev;
  wire       hold_ok = (hcnt == HW'(HOLD_CYC));
  wire       prime   = !init_done && (pcnt == 2'd2);
  wire       pin_ok  = init_done && mode_hw && !reg0_b7 && hold_ok && !busy;
  wire       one_chg = pin_ok && (diff == 2'b01 || diff == 2'b10);
  wire       two_chg = pin_ok && (diff == 2'b11);
  wire       host_go = init_done && !mode_hw && !busy && (pend || host_req);
  wire       start   = prime || one_chg || host_go;

  assign bus_en = init_done && !mode_hw;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      sy1 <= '0;
      sy2 <= '0;
    end else begin
      sy1 <= {strap_in, sel1_in, sel0_in};
      sy2 <= sy1;
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      pcnt      <= '0;
      init_done <= 1'b0;
      mode_hw   <= 1'b0;
      prev      <= '0;
      hcnt      <= '0;
    end else begin
      if (!init_done) pcnt <= pcnt + 2'd1;
      if (prime) begin
        init_done <= 1'b1;
        mode_hw   <= sy2[2];
      end
      prev <= pins;
      if (!hold_ok) hcnt <= hcnt + HW'(1);
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      load_stb  <= 1'b0;
      load_idx  <= '0;
      load_dflt <= 1'b0;
      err       <= 1'b0;
    end else begin
      load_stb <= start;
      if (prime) begin
        load_idx  <= sy2[2] ? pins : 2'd0;
        load_dflt <= !sy2[2] && reg0_b7;
      end else if (one_chg) begin
        load_idx  <= pins;
        load_dflt <= 1'b0;
      end else if (host_go) begin
        load_idx  <= host_req ? host_idx : pend_idx;
        load_dflt <= 1'b0;
      end
      if (start) err <= 1'b0;
      else if (two_chg) err <= 1'b1;
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      busy     <= 1'b0;
      wcnt     <= '0;
      pend     <= 1'b0;
      pend_idx <= '0;
    end else begin
      if (start) begin
        busy <= 1'b1;
        wcnt <= WW'(WIN_CYC - 1);
      end else if (busy) begin
        if (wcnt == '0) busy <= 1'b0;
        else wcnt <= wcnt - WW'(1);
      end
      if (host_go) pend <= 1'b0;
      else if (busy && bus_en && host_req) begin
        pend     <= 1'b1;
        pend_idx <= host_idx;
      end
    end
endmodule

// File: rtl/cfg_sel_ctrl_chk.sv
module cfg_sel_ctrl_chk (
  input logic       clk,
  input logic       por_n,
  input logic       load_stb,
  input logic [1:0] load_idx,
  input logic       load_dflt,
  input logic       bus_en,
  input logic       busy,
  input logic       err
);
  // R10
  stb_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
    load_stb |=> !load_stb);
  // R8
  stb_busy_chk: assert property (@(posedge clk) disable iff (!por_n)
    load_stb |-> busy);
  // R1
  mode_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    bus_en |=> bus_en);
  // R7
  err_nostb_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(err) |-> !load_stb);
  // R6
  err_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    load_stb |-> !err);
  // R3
  dflt_bus_chk: assert property (@(posedge clk) disable iff (!por_n)
    (load_stb && load_dflt) |-> (bus_en && load_idx == 2'd0));
endmodule

bind cfg_sel_ctrl cfg_sel_ctrl_chk i_chk (.*);

// File: tb/test_cfg_sel_ctrl.sv
module test_cfg_sel_ctrl;
  localparam int CLK_HZ = 100_000;
  localparam int HOLD = CLK_HZ / 100;
  localparam int WIN  = CLK_HZ / 1000;

  logic clk = 0, por_n = 0, strap_in = 0, sel1_in = 0, sel0_in = 0;
  logic reg0_b7 = 0, host_req = 0;
  logic [1:0] host_idx = 0;
  logic load_stb, load_dflt, bus_en, busy, err;
  logic [1:0] load_idx;

  cfg_sel_ctrl #(.CLK_HZ(CLK_HZ)) i_cfg_sel_ctrl (.*);

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0, stb_cnt = 0, cyc = 0, brun = 0, blen = 0;
  int fall_cyc = 0, stb_cyc = 0;
  logic [1:0] last_idx = 0;
  logic last_dflt = 0, pbusy = 0, done = 0;

  always @(negedge clk) begin
    cyc++;
    if (load_stb) begin stb_cnt++; last_idx = load_idx; last_dflt = load_dflt; stb_cyc = cyc; end
    if (busy) brun++;
    else if (brun != 0) begin blen = brun; brun = 0; end
    if (pbusy && !busy) fall_cyc = cyc;
    pbusy = busy;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  task automatic cyc_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic strap, input logic b7, input logic [1:0] pins);
    @(negedge clk);
    por_n = 0; strap_in = strap; reg0_b7 = b7; {sel1_in, sel0_in} = pins;
    cyc_wait(3);
    chk(!load_stb && !busy && !bus_en && !err, "R2 reset state", {load_stb, busy, bus_en, err}, 0);
    por_n = 1;
  endtask

  task automatic pulse_host(input logic [1:0] idx);
    @(negedge clk); host_req = 1; host_idx = idx;
    @(negedge clk); host_req = 0;
  endtask

  task automatic set_pins(input logic [1:0] p);
    @(negedge clk); {sel1_in, sel0_in} = p;
  endtask

  function automatic logic [1:0] flip_mask(input int r);
    return (r % 3 == 0) ? 2'b01 : (r % 3 == 1) ? 2'b10 : 2'b11;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int base;
    logic [1:0] cur, cfg, m;
    logic eerr;
    void'($urandom(32'h5EED));
    // hardware-select mode
    do_reset(1, 0, 2'b10);
    base = stb_cnt;
    cyc_wait(20);
    chk(stb_cnt - base == 1, "R2 one initial strobe", stb_cnt - base, 1);
    chk(last_idx == 2'b10 && !last_dflt, "R2 initial index", last_idx, 2);
    chk(!bus_en, "R1 hw mode bus_en", bus_en, 0);
    cyc_wait(WIN + 10);
    chk(blen == WIN, "R8 busy length", blen, WIN);
    strap_in = 0;
    set_pins(2'b11);
    cyc_wait(20);
    chk(stb_cnt - base == 1, "R5 change in holdoff ignored", stb_cnt - base, 1);
    chk(!bus_en, "R1 strap change ignored", bus_en, 0);
    pulse_host(2'b01);
    cyc_wait(10);
    chk(stb_cnt - base == 1, "R4 host ignored in hw mode", stb_cnt - base, 1);
    wait (cyc > HOLD + 50); @(negedge clk);
    set_pins(2'b01);
    cyc_wait(10);
    chk(stb_cnt - base == 2 && last_idx == 2'b01, "R6 single change load", last_idx, 1);
    cyc_wait(20);
    set_pins(2'b00);
    cyc_wait(WIN + 10);
    chk(stb_cnt - base == 2, "R8 change during busy ignored", stb_cnt - base, 2);
    chk(blen == WIN, "R8 busy length run-time", blen, WIN);
    cur = 2'b00; cfg = 2'b01; eerr = 0;
    for (int i = 0; i < 30; i++) begin
      m = flip_mask($urandom);
      base = stb_cnt;
      cur = cur ^ m;
      set_pins(cur);
      cyc_wait(8);
      if (m == 2'b11) begin
        eerr = 1;
        chk(stb_cnt == base, "R7 double change no strobe", stb_cnt - base, 0);
      end else begin
        eerr = 0; cfg = cur;
        chk(stb_cnt == base + 1, "R6 random single change", stb_cnt - base, 1);
      end
      chk(err == eerr, "R7 err flag", err, eerr);
      chk(last_idx == cfg, "R6 random index", last_idx, cfg);
      cyc_wait(WIN + 4);
    end
    reg0_b7 = 1;
    base = stb_cnt;
    set_pins(cur ^ 2'b01);
    cyc_wait(10);
    chk(stb_cnt == base, "R5 reg0_b7 locks pins", stb_cnt - base, 0);
    // serial-bus mode, defaults
    do_reset(0, 1, 2'b11);
    base = stb_cnt;
    cyc_wait(20);
    chk(stb_cnt - base == 1 && last_dflt && last_idx == 0, "R3 bus defaults load", {last_dflt, last_idx}, 4);
    chk(bus_en, "R1 bus mode bus_en", bus_en, 1);
    strap_in = 1;
    cyc_wait(WIN + 10);
    chk(bus_en, "R1 strap change ignored bus", bus_en, 1);
    set_pins(2'b01);
    cyc_wait(10);
    set_pins(2'b00);
    cyc_wait(10);
    chk(stb_cnt - base == 1, "R4 pins ignored in bus mode", stb_cnt - base, 1);
    pulse_host(2'b10);
    cyc_wait(4);
    chk(stb_cnt - base == 2 && last_idx == 2'b10 && !last_dflt, "R4 host load", last_idx, 2);
    cyc_wait(20);
    pulse_host(2'b01);
    cyc_wait(5);
    pulse_host(2'b11);
    cyc_wait(5);
    chk(stb_cnt - base == 2, "R9 request held while busy", stb_cnt - base, 2);
    wait (!busy); cyc_wait(3);
    chk(stb_cnt - base == 3 && last_idx == 2'b11, "R9 pending served latest", last_idx, 3);
    chk(stb_cyc - fall_cyc == 1, "R9 served first idle cycle", stb_cyc - fall_cyc, 1);
    for (int i = 0; i < 20; i++) begin
      logic [1:0] hi;
      hi = 2'($urandom);
      wait (!busy); cyc_wait(1 + ($urandom % 3));
      base = stb_cnt;
      pulse_host(hi);
      cyc_wait(3);
      chk(stb_cnt == base + 1 && last_idx == hi, "R4 random host", last_idx, hi);
    end
    // serial-bus mode, configuration 0
    do_reset(0, 0, 2'b10);
    base = stb_cnt;
    cyc_wait(20);
    chk(stb_cnt - base == 1 && !last_dflt && last_idx == 0, "R3 bus config 0 load", {last_dflt, last_idx}, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule